// File: doc/BRIEF.md
# Page-Load Write Sequencer

This block sits between a parallel memory bus and a byte-wide non-volatile storage array. It gathers a burst of byte writes into a staging buffer that holds one page. When the bus goes quiet, it commits the loaded bytes to the array in one internally timed program cycle. A page is 64 bytes. The low address bits pick the byte within the page, and the high bits name the page.

The first byte accepted in a burst locks the page. Later bytes for that page land in their slots, and a byte written twice keeps its last value. Each accepted byte restarts a load timer. A byte for any other page is dropped and raises a one-cycle reject flag. Once the load timer runs a full window with no accepted byte, the block turns busy for a fixed program time. During that time it walks the slots in ascending order and issues one array write for each slot that was loaded. Bus writes are ignored while it is busy.

The load window and the program time are parameters in clock cycles, so a simulation can use short values. The program time must be at least one page long in cycles.

Top module: `page_load_sequencer`

## Requirements
- R1: After reset, busy, loading, page_reject and commit_we are all 0.
- R2: A byte is accepted only on a clock edge where ce_n=0, we_n=0 and oe_n=1. Each such edge is one byte write; any other combination changes nothing.
- R3: The first accepted byte while idle locks the page address addr[12:6], stores the data in slot addr[5:0], and loading is 1 from the next cycle.
- R4: While loading, a byte whose addr[12:6] differs from the locked page is dropped. It is never committed and does not restart the load timer, and page_reject is 1 for exactly the cycle after that edge.
- R5: Each accepted byte restarts the load timer. busy becomes 1 after the LOAD_CYCLES-th clock edge following the last accepted byte, provided no byte is accepted at any of those edges, and loading returns to 0 at the same time.
- R6: busy stays 1 for exactly PROG_CYCLES cycles and then returns to 0.
- R7: In the busy cycle with index s (counting from 0), commit_we is 1 only if slot s was loaded. commit_addr is then {locked page, s}, and commit_data is the last byte written to that slot.
- R8: Slots that were not loaded in the burst produce no commit_we pulse, so the array locations they map to keep their values.
- R9: Write strobes during busy are ignored: they add no commit, raise no page_reject, and leave the block idle (loading 0) when busy ends.
- R10: After a program cycle all slots count as empty. A new burst may target any page, and only its own bytes are committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low (must be high to write) |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 13 | Byte address: [12:6] page, [5:0] slot |
| wdata | input | 8 | Write data |
| busy | output | 1 | Program cycle in progress |
| loading | output | 1 | A burst is being collected |
| page_reject | output | 1 | One-cycle pulse: byte for another page dropped |
| commit_we | output | 1 | Array write strobe |
| commit_addr | output | 13 | Array write address |
| commit_data | output | 8 | Array write data |

## Verification
A wrong load timer shows up as busy rising one or more cycles early or late after the last byte. The bench checks this cycle by cycle from the accepting edge, including the case where a dropped byte lands in the middle of the window. Corrupt slot-valid state or buffer data shows up during the program cycle itself: a missing, extra, misplaced or wrong-valued commit is compared against the scoreboard in the very cycle it occurs. State that leaks from one burst into the next, or a strobe that is not ignored while busy, appears as extra commits in the following program cycle or as page_reject and loading during busy.

// File: rtl/page_load_sequencer.sv
module page_load_sequencer #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int OFFS_W      = 6,
  parameter int LOAD_CYCLES = 16,
  parameter int PROG_CYCLES = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              loading,
  output logic              page_reject,
  output logic              commit_we,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  localparam int PAGE_BYTES = 1 << OFFS_W;
  localparam int PAGE_W     = ADDR_W - OFFS_W;
  localparam int LT_W       = $clog2(LOAD_CYCLES + 1);
  localparam int PC_W       = $clog2(PROG_CYCLES + 1);
  localparam logic [LT_W-1:0] LT_LAST  = LT_W'(LOAD_CYCLES - 1);
  localparam logic [PC_W-1:0] PC_LAST  = PC_W'(PROG_CYCLES - 1);
  localparam logic [PC_W-1:0] SCAN_END = PC_W'(PAGE_BYTES);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} seq_state_t;

  seq_state_t              state;
  logic [PAGE_W-1:0]       page_q;
  logic [PAGE_BYTES-1:0]   valid_q;
  logic [DATA_W-1:0]       page_buf [PAGE_BYTES];
  logic [LT_W-1:0]         load_t;
  logic [PC_W-1:0]         prog_t;

  wire              wr_ok     = !ce_n && !we_n && oe_n;
  wire [PAGE_W-1:0] wr_page   = addr[ADDR_W-1:OFFS_W];
  wire [OFFS_W-1:0] wr_slot   = addr[OFFS_W-1:0];
  wire              same_page = (wr_page == page_q);
  wire              take      = wr_ok && ((state == ST_IDLE) || ((state == ST_LOAD) && same_page));
  wire              drop      = wr_ok && (state == ST_LOAD) && !same_page;
  wire              expire    = (state == ST_LOAD) && !take && (load_t == LT_LAST);
  wire              prog_done = (state == ST_PROG) && (prog_t == PC_LAST);
  wire [OFFS_W-1:0] scan_slot = prog_t[OFFS_W-1:0];

  assign busy        = (state == ST_PROG);
  assign loading     = (state == ST_LOAD);
  assign commit_we   = busy && (prog_t < SCAN_END) && valid_q[scan_slot];
  assign commit_addr = {page_q, scan_slot};
  assign commit_data = page_buf[scan_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      page_q      <= '0;
      valid_q     <= '0;
      load_t      <= '0;
      prog_t      <= '0;
      page_reject <= 1'b0;
    end else begin
      page_reject <= drop;
      case (state)
        ST_IDLE: if (take) begin
          state            <= ST_LOAD;
          page_q           <= wr_page;
          valid_q[wr_slot] <= 1'b1;
          load_t           <= '0;
        end
        ST_LOAD: begin
          if (take) begin
            valid_q[wr_slot] <= 1'b1;
            load_t           <= '0;
          end else if (expire) begin
            state  <= ST_PROG;
            prog_t <= '0;
          end else begin
            load_t <= load_t + LT_W'(1);
          end
        end
        ST_PROG: begin
          if (prog_done) begin
            state   <= ST_IDLE;
            valid_q <= '0;
          end else begin
            prog_t <= prog_t + PC_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take) page_buf[wr_slot] <= wdata;
  end

  logic [PC_W-1:0] chk_busy_len;
  logic [LT_W-1:0] chk_quiet;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_busy_len <= '0;
      chk_quiet    <= '0;
    end else begin
      chk_busy_len <= busy ? chk_busy_len + PC_W'(1) : '0;
      chk_quiet    <= (loading && !(wr_ok && same_page)) ? chk_quiet + LT_W'(1) : '0;
    end
  end

  AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (chk_busy_len == PC_W'(PROG_CYCLES)));  // R6
  AST_LOAD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    loading |-> (chk_quiet < LT_W'(LOAD_CYCLES)));  // R5
  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(loading));  // R5
  AST_COMMIT_ONE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_we && $past(commit_we)) |-> (commit_addr[ADDR_W-1:OFFS_W] == $past(commit_addr[ADDR_W-1:OFFS_W])));  // R7
  AST_REJECT_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    page_reject |-> $past(loading));  // R4
  AST_NO_REJECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !page_reject);  // R9
  AST_IDLE_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !loading);  // R9
endmodule

// File: tb/page_load_sequencer_bench.sv
module page_load_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L = 16;
  localparam int P = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        busy, loading, page_reject, commit_we;
  logic [12:0] commit_addr;
  logic [7:0]  commit_data;

  page_load_sequencer #(.LOAD_CYCLES(L), .PROG_CYCLES(P)) u_page_load_sequencer (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .busy(busy), .loading(loading),
    .page_reject(page_reject), .commit_we(commit_we),
    .commit_addr(commit_addr), .commit_data(commit_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  logic [20:0] exp_q [$];
  logic [7:0]  sh_data [64];
  logic        sh_valid [64];
  int          busy_run = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && commit_we) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected commit", {19'd0, commit_addr}, 32'hFFFF);
      end else begin
        logic [20:0] it;
        it = exp_q.pop_front();
        check("R7 commit addr", {19'd0, commit_addr}, {19'd0, it[20:8]});
        check("R7 commit data", {24'd0, commit_data}, {24'd0, it[7:0]});
        check("R7 slot timing", busy_run, {26'd0, commit_addr[5:0]});
      end
    end
    busy_run = (rst_n && busy) ? busy_run + 1 : 0;
  end

  task automatic clear_shadow();
    for (int i = 0; i < 64; i++) sh_valid[i] = 1'b0;
  endtask

  task automatic write_byte(input logic [12:0] a, input logic [7:0] d, input bit expect_take);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    if (expect_take) begin
      sh_valid[a[5:0]] = 1'b1;
      sh_data[a[5:0]]  = d;
    end
  endtask

  task automatic end_burst(input logic [6:0] page);
    for (int i = 0; i < 64; i++)
      if (sh_valid[i]) exp_q.push_back({page, i[5:0], sh_data[i]});
    clear_shadow();
  endtask

  task automatic wait_commit(input int k0, input bit inject);
    for (int k = k0; k <= L + P; k++) begin
      bit eb;
      @(negedge clk);
      eb = (k >= L) && (k < L + P);
      check("R5/R6 busy window", {31'd0, busy}, {31'd0, eb});
      if (eb) begin
        check("R9 loading low while busy", {31'd0, loading}, 32'd0);
        check("R9 no reject while busy", {31'd0, page_reject}, 32'd0);
      end
      if (inject && k == L + 3) begin
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 13'h1F05; wdata = 8'hEE;
      end
      if (inject && k == L + 5) begin
        ce_n = 1'b1; we_n = 1'b1; addr = 13'h0246;
      end
    end
    check("R9 idle after program", {31'd0, loading}, 32'd0);
    check("R8 all expected commits seen", exp_q.size(), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    clear_shadow();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 loading", {31'd0, loading}, 32'd0);
    check("R1 page_reject", {31'd0, page_reject}, 32'd0);
    check("R1 commit_we", {31'd0, commit_we}, 32'd0);

    // R2: blocked combinations
    ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b1; addr = 13'h0141;
    @(negedge clk); check("R2 ce_n high blocks", {31'd0, loading}, 32'd0);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); check("R2 oe_n low blocks", {31'd0, loading}, 32'd0);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); check("R2 we_n high blocks", {31'd0, loading}, 32'd0);
    ce_n = 1'b1; we_n = 1'b1;

    // R3, R7, R8: burst on page 5 with an overwritten slot
    write_byte({7'd5, 6'd3}, 8'h11, 1);
    check("R3 loading after first byte", {31'd0, loading}, 32'd1);
    write_byte({7'd5, 6'd0}, 8'hA5, 1);
    write_byte({7'd5, 6'd63}, 8'h3C, 1);
    write_byte({7'd5, 6'd3}, 8'h77, 1);
    end_burst(7'd5);
    wait_commit(1, 0);

    // R4, R9: dropped byte mid-window, strobes during program
    write_byte({7'd9, 6'd10}, 8'h42, 1);
    write_byte({7'd12, 6'd11}, 8'h99, 0);
    check("R4 reject pulse", {31'd0, page_reject}, 32'd1);
    @(negedge clk);
    check("R4 reject is one cycle", {31'd0, page_reject}, 32'd0);
    end_burst(7'd9);
    wait_commit(4, 1);

    // R10: new page, old slots must not reappear
    write_byte({7'd127, 6'd2}, 8'h5A, 1);
    write_byte({7'd127, 6'd1}, 8'hC3, 1);
    end_burst(7'd127);
    wait_commit(1, 0);

    // R5: restart of the load timer
    write_byte({7'd0, 6'd0}, 8'h01, 1);
    for (int i = 0; i < L - 3; i++) begin
      @(negedge clk);
      check("R5 no early commit", {31'd0, busy}, 32'd0);
    end
    write_byte({7'd0, 6'd1}, 8'h02, 1);
    end_burst(7'd0);
    wait_commit(1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule